// File: doc/BRIEF.md
# Ternary Prefix Lookup Table

This block is a small ternary match table for route lookup. Each entry holds a key pattern, a per-bit care mask, a valid flag and an output-port code. A bit whose care flag is clear is a wildcard and matches either key value. Software or a control engine fills the table one entry at a time through a write port. The ordering of entries is left to that writer: placing longer prefixes at lower indices gives longest-prefix routing.

A search presents a destination key. All entries compare against it at once, and the first matching entry by index wins. One clock edge after the search strobe, the block presents the hit flag, the index of the winner and the winner's port code, marked by a result strobe.

Both streams are strobe-only. The search input is accepted on every cycle in which `srch_valid` is high, so it never stalls the sender. The result output has no ready signal: the consumer takes it in the cycle `res_valid` is high. The result registers hold their values until the next search.

Top module: `tcam_lookup`

## Requirements
- R1: An entry matches a key when every bit whose care flag is 1 equals the key bit. Bits whose care flag is 0 match both 0 and 1.
- R2: An entry whose valid flag is 0 never matches. After reset every entry is invalid, so every search misses.
- R3: When more than one entry matches, the result reports the numerically smallest matching index.
- R4: `res_valid` is high exactly in the cycle after a cycle with `srch_valid` high. The result fields in that cycle belong to that search.
- R5: On a hit, `res_hit` is 1, `res_idx` is the winning index, and `res_port` is the port code written to that entry.
- R6: On a miss, `res_hit`, `res_idx` and `res_port` are all 0.
- R7: A search issued in the same cycle as a write sees the table as it was before the write. Searches from the next cycle on see the written entry.
- R8: A write with `wr_en` high replaces all four fields of entry `wr_idx` (value, care mask, valid flag, port code). The other entries are left unchanged.
- R9: In a cycle after one with `srch_valid` low, `res_hit`, `res_idx` and `res_port` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for one table entry |
| wr_idx | input | IDX_W | Entry index written |
| wr_value | input | KEY_W | Pattern bits of the entry |
| wr_care | input | KEY_W | Care mask, 1 = bit compared, 0 = wildcard |
| wr_valid | input | 1 | Valid flag stored with the entry |
| wr_port | input | PORT_W | Output-port code stored with the entry |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | KEY_W | Destination key searched |
| res_valid | output | 1 | Result strobe, one cycle after the search |
| res_hit | output | 1 | At least one valid entry matched |
| res_idx | output | IDX_W | Lowest matching index, 0 on a miss |
| res_port | output | PORT_W | Port code of the winning entry, 0 on a miss |

## Verification
The hardest case to reach from the ports is a search that overlaps a write to the same entry. The search has to see the old contents and the very next search has to see the new ones. The bench drives the write and the search in the same cycle, with a key that only the new contents would match, and follows at once with a repeat of that search. The priority behaviour needs several live matches at once. The bench loads the classic overlapping-prefix table and many computed tables with mixed care masks, then sweeps all keys against each, so that multi-way overlaps occur at every index.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned DEF_ENTRIES = 4;
  localparam int unsigned DEF_KEY_W   = 5;
  localparam int unsigned DEF_PORT_W  = 3;

  // Ternary compare of one stored pattern against a key; care=1 bits compared.
  function automatic logic tern_eq(input logic [63:0] value,
                                   input logic [63:0] care,
                                   input logic [63:0] key);
    return ((value ^ key) & care) == 64'd0;
  endfunction
endpackage

// File: rtl/tcam_entry.sv
module tcam_entry #(
  parameter int unsigned KEY_W  = 5,
  parameter int unsigned PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KEY_W-1:0]  ld_value,
  input  logic [KEY_W-1:0]  ld_care,
  input  logic              ld_valid,
  input  logic [PORT_W-1:0] ld_port,
  input  logic [KEY_W-1:0]  key,
  output logic              hit_line,
  output logic              is_valid,
  output logic [PORT_W-1:0] port_code
);
  logic [KEY_W-1:0] value_q;
  logic [KEY_W-1:0] care_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q   <= '0;
      care_q    <= '0;
      is_valid  <= 1'b0;
      port_code <= '0;
    end else if (load) begin
      value_q   <= ld_value;
      care_q    <= ld_care;
      is_valid  <= ld_valid;
      port_code <= ld_port;
    end
  end

  // Line starts asserted; any cared-for differing bit pulls it low.
  logic [KEY_W-1:0] diff_bits;
  assign diff_bits = (value_q ^ key) & care_q;
  assign hit_line  = is_valid && (diff_bits == '0);
endmodule

// File: rtl/tcam_first_match.sv
module tcam_first_match #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     lines,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);
  always_comb begin
    grant   = '0;
    win_idx = '0;
    // Walk downward so the lowest set index is the last one written.
    for (int i = N - 1; i >= 0; i--) begin
      if (lines[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    any = |lines;
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned KEY_W   = DEF_KEY_W,
  parameter int unsigned PORT_W  = DEF_PORT_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_care,
  input  logic              wr_valid,
  input  logic [PORT_W-1:0] wr_port,
  input  logic              srch_valid,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [PORT_W-1:0] res_port
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] grant_vec;
  logic [PORT_W-1:0]  port_tab [ENTRIES];
  logic [IDX_W-1:0]   win_idx;
  logic               any_hit;
  logic [PORT_W-1:0]  win_port;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    tcam_entry #(.KEY_W(KEY_W), .PORT_W(PORT_W)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sel),
      .ld_value  (wr_value),
      .ld_care   (wr_care),
      .ld_valid  (wr_valid),
      .ld_port   (wr_port),
      .key       (srch_key),
      .hit_line  (match_vec[e]),
      .is_valid  (valid_vec[e]),
      .port_code (port_tab[e])
    );
  end

  tcam_first_match #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc (
    .lines   (match_vec),
    .grant   (grant_vec),
    .win_idx (win_idx),
    .any     (any_hit)
  );

  // One-hot grant selects the port code; zero grant yields zero.
  always_comb begin
    win_port = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      win_port = win_port | (port_tab[e] & {PORT_W{grant_vec[e]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_port  <= '0;
    end else begin
      res_valid <= srch_valid;
      if (srch_valid) begin
        res_hit  <= any_hit;
        res_idx  <= win_idx;
        res_port <= win_port;
      end
    end
  end
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned PORT_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_valid,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [PORT_W-1:0]  res_port,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] grant_vec
);
  assert_strobe_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |=> res_valid);

  assert_no_spurious_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_valid |=> !res_valid);

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_port == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_valid |=> ($stable(res_hit) && $stable(res_idx) && $stable(res_port)));

  assert_invalid_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~valid_vec) == '0);

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_winner_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~match_vec) == '0);

  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |->
      (((grant_vec - {{(ENTRIES-1){1'b0}}, 1'b1}) & match_vec) == '0));

  assert_some_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec != '0) |-> (grant_vec != '0));
endmodule

bind tcam_lookup tcam_lookup_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W),
  .PORT_W  (PORT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srch_valid (srch_valid),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_idx    (res_idx),
  .res_port   (res_port),
  .match_vec  (match_vec),
  .valid_vec  (valid_vec),
  .grant_vec  (grant_vec)
);

// File: tb/sim_tcam_lookup.sv
`timescale 1ns/1ps
module sim_tcam_lookup;
  localparam int N  = 4;
  localparam int KW = 5;
  localparam int PW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [KW-1:0] wr_value = '0;
  logic [KW-1:0] wr_care = '0;
  logic          wr_valid = 1'b0;
  logic [PW-1:0] wr_port = '0;
  logic          srch_valid = 1'b0;
  logic [KW-1:0] srch_key = '0;
  logic          res_valid;
  logic          res_hit;
  logic [IW-1:0] res_idx;
  logic [PW-1:0] res_port;

  always #4 clk = ~clk;

  tcam_lookup #(.ENTRIES(N), .KEY_W(KW), .PORT_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_care(wr_care), .wr_valid(wr_valid),
    .wr_port(wr_port), .srch_valid(srch_valid), .srch_key(srch_key),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
    .res_port(res_port)
  );

  // Bench-side table model
  logic [KW-1:0] m_val  [N];
  logic [KW-1:0] m_care [N];
  logic          m_vld  [N];
  logic [PW-1:0] m_port [N];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_for(input logic [KW-1:0] key, output bit hit,
                            output int idx, output int port);
    hit = 1'b0; idx = 0; port = 0;
    for (int e = 0; e < N; e++) begin
      if (!hit && m_vld[e] && (((m_val[e] ^ key) & m_care[e]) == '0)) begin
        hit = 1'b1; idx = e; port = int'(m_port[e]);
      end
    end
  endtask

  task automatic put(input int e, input logic [KW-1:0] v, input logic [KW-1:0] c,
                     input logic vl, input logic [PW-1:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(e); wr_value = v; wr_care = c;
    wr_valid = vl; wr_port = p;
    m_val[e] = v; m_care[e] = c; m_vld[e] = vl; m_port[e] = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic search_check(input logic [KW-1:0] key, input string req);
    bit hit; int idx; int port;
    expect_for(key, hit, idx, port);
    @(negedge clk);
    srch_valid = 1'b1; srch_key = key;
    @(negedge clk);
    srch_valid = 1'b0;
    check(req, "res_valid", int'(res_valid), 1);
    check(req, "res_hit", int'(res_hit), int'(hit));
    check(req, "res_idx", int'(res_idx), idx);
    check(req, "res_port", int'(res_port), port);
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < (1 << KW); k++) search_check(KW'(k), req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    for (int e = 0; e < N; e++) begin
      m_val[e] = '0; m_care[e] = '0; m_vld[e] = 1'b0; m_port[e] = '0;
    end
    repeat (3) @(negedge clk);
    // Reset state of outputs
    check("R4", "reset res_valid", int'(res_valid), 0);
    check("R6", "reset res_hit", int'(res_hit), 0);
    rst_n = 1'b1;

    // R2 R6: empty table misses every key
    sweep("R2");

    // R1 R3 R5: overlapping prefixes; key 01101 hits entries 1 and 2, index 1 wins
    put(0, 5'b10100, 5'b11100, 1'b1, 3'd1);
    put(1, 5'b01100, 5'b11110, 1'b1, 3'd2);
    put(2, 5'b01100, 5'b11100, 1'b1, 3'd3);
    put(3, 5'b10011, 5'b11111, 1'b1, 3'd4);
    search_check(5'b01101, "R3");
    check("R3", "example idx", int'(res_idx), 1);
    check("R5", "example port", int'(res_port), 2);
    sweep("R1");

    // R8 R1 R3: computed tables with mixed wildcards and validity
    for (int r = 0; r < 8; r++) begin
      for (int e = 0; e < N; e++) begin
        put(e, KW'(e * 13 + r * 5 + 3), KW'((e * 11 + r * 19 + 6) | (r & 1)),
            ((e + r) % 3) != 0, PW'(e + r + 1));
      end
      sweep("R8");
    end
    // All wildcards on every entry: index 0 always wins
    for (int e = 0; e < N; e++) put(e, KW'(e), '0, 1'b1, PW'(7 - e));
    sweep("R3");

    // R8: rewrite only entry 0 as invalid, others stay; index 1 now wins
    put(0, '0, '0, 1'b0, 3'd0);
    sweep("R8");

    // R7: write and search in the same cycle
    for (int e = 0; e < N; e++) put(e, '0, '1, 1'b0, '0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd2; wr_value = 5'b00101; wr_care = '1;
    wr_valid = 1'b1; wr_port = 3'd6;
    srch_valid = 1'b1; srch_key = 5'b00101;
    @(negedge clk);
    wr_en = 1'b0;
    m_val[2] = 5'b00101; m_care[2] = '1; m_vld[2] = 1'b1; m_port[2] = 3'd6;
    check("R7", "same-cycle res_valid", int'(res_valid), 1);
    check("R7", "same-cycle res_hit", int'(res_hit), 0);
    @(negedge clk);
    srch_valid = 1'b0;
    check("R7", "next-cycle res_hit", int'(res_hit), 1);
    check("R7", "next-cycle res_idx", int'(res_idx), 2);
    check("R7", "next-cycle res_port", int'(res_port), 6);

    // R9 R4: idle cycles hold the result and drop the strobe
    repeat (4) begin
      @(negedge clk);
      check("R4", "idle res_valid", int'(res_valid), 0);
      check("R9", "idle res_hit", int'(res_hit), 1);
      check("R9", "idle res_idx", int'(res_idx), 2);
      check("R9", "idle res_port", int'(res_port), 6);
    end
    // R6 after a hit: a miss clears fields
    search_check(5'b11111, "R6");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule